// File: doc/BRIEF.md
# Marker-Based ADC Frame Aligner

This block sits behind an eight-channel multiplexed ADC whose conversions arrive as a stream of 8-bit samples. The samples are read in groups of eight, and the multiplexer may have slipped, so the first sample of a group can belong to any channel. Three channels are wired to fixed levels to act as in-band markers. Channel 0 is tied high (0xFF) and channel 1 is tied low (0x00); together they form a start marker. Channel 7 is tied low and forms the end marker. The remaining channels 2 to 6 carry the measured data.

The aligner collects a complete group of eight accepted samples into a holding buffer. It then treats the buffer as a ring and tests all eight rotations for the marker pattern. When one rotation matches, the five data channels are presented in channel order with a one-cycle valid pulse. A group with no consistent marker set is dropped and flagged with a one-cycle error pulse. Each group is aligned on its own, with no memory of earlier groups. The next group is collected while the previous one is searched, so samples may arrive on every cycle.

Top module: `adc_frame_align`

## Requirements
- R1: While rst_ni is low and after it is released, out_valid_o and frame_error_o are 0 and data_o is 0. A partly collected group is discarded by reset, and the first eight samples accepted after reset form the next group.
- R2: A group consists of exactly eight samples accepted with in_valid_i high, counted in order of arrival from buffer position 0 to 7. Cycles with in_valid_i low are ignored and may fall anywhere inside a group.
- R3: Rotation r (0..7) matches when position r holds 0xFF, position (r+1) mod 8 holds 0x00, and position (r+7) mod 8 holds 0x00. The last of these is the end marker that follows the five data samples.
- R4: For the chosen rotation r, data_o[8k+7:8k] equals position (r+2+k) mod 8 for k = 0..4. Byte 0 is channel 2, the first sample after the start marker, and byte 4 is channel 6, the sample just before the end marker.
- R5: A matching rotation is found at every start position 0..7, including those whose markers or data wrap from position 7 back to position 0.
- R6: A group with no matching rotation produces a one-cycle pulse on frame_error_o with out_valid_o low, and data_o keeps its previous value.
- R7: When several rotations match, the lowest matching r is used.
- R8: Exactly one of out_valid_o or frame_error_o pulses for one cycle per group, two clock edges after the edge that accepts the group's eighth sample.
- R9: Groups sent back to back, with no idle cycle between them, are each aligned or rejected on their own, and each produces its own result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | sample_i is accepted on this edge |
| sample_i | input | 8 | ADC sample |
| out_valid_o | output | 1 | One-cycle pulse: data_o holds a new aligned frame |
| data_o | output | 40 | Channels 2..6, channel 2 in the low byte |
| frame_error_o | output | 1 | One-cycle pulse: the last group had no valid markers |

## Verification
Every result is due two clock edges after the edge that accepts the eighth sample of its group. The first edge loads the holding buffer; the second registers the outcome of the search. A falling-edge monitor stamps each valid or error pulse with the cycle count, and the driver stamps the cycle in which it presents each eighth sample. Each check therefore compares the difference of the two stamps to exactly two and then confirms that no second pulse follows in the idle window. Back-to-back groups reuse the same stamping, so overlapped collection and search are checked at the same latency.

// File: rtl/adc_align_pkg.sv
package adc_align_pkg;
  localparam int unsigned SMP_W_DEF = 8;
  localparam int unsigned GRP_N_DEF = 8;
  localparam logic [7:0]  MARK_HI   = 8'hFF;
  localparam logic [7:0]  MARK_LO   = 8'h00;
endpackage

// File: rtl/adc_grp_collect.sv
module adc_grp_collect #(
  parameter int unsigned SMP_W = 8,
  parameter int unsigned GRP_N = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       in_valid_i,
  input  logic [SMP_W-1:0]           sample_i,
  output logic                       grp_vld_o,
  output logic [GRP_N-1:0][SMP_W-1:0] grp_o
);
  localparam int unsigned CNT_W = $clog2(GRP_N);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GRP_N - 1);

  logic [CNT_W-1:0]            cnt_q;
  logic [GRP_N-1:0][SMP_W-1:0] fill_q;
  logic                        last_w;

  assign last_w = in_valid_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fill_q <= '0;
    end else if (in_valid_i) begin
      fill_q[cnt_q] <= sample_i;
      cnt_q         <= last_w ? '0 : cnt_q + 1'b1;
    end
  end

  // holding buffer: released to the matcher while the next group fills
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_vld_o <= 1'b0;
      grp_o     <= '0;
    end else begin
      grp_vld_o <= last_w;
      if (last_w) begin
        for (int i = 0; i < GRP_N - 1; i++) grp_o[i] <= fill_q[i];
        grp_o[GRP_N-1] <= sample_i;
      end
    end
  end

  p_cnt_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(cnt_q));
  p_grp_needs_sample_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_vld_o |-> $past(in_valid_i));
endmodule

// File: rtl/adc_rot_match.sv
module adc_rot_match #(
  parameter int unsigned SMP_W = 8,
  parameter int unsigned GRP_N = 8,
  parameter logic [SMP_W-1:0] HI = '1,
  parameter logic [SMP_W-1:0] LO = '0
) (
  input  logic [GRP_N-1:0][SMP_W-1:0]   grp_i,
  output logic                          hit_o,
  output logic [GRP_N-3-1:0][SMP_W-1:0] dat_o
);
  localparam int unsigned DAT_N = GRP_N - 3;

  logic [GRP_N-1:0] hit;
  logic [GRP_N-1:0] sel;
  logic [SMP_W-1:0] acc [GRP_N+1][DAT_N];

  for (genvar r = 0; r < GRP_N; r++) begin : g_rot
    assign hit[r] = (grp_i[r] == HI) &&
                    (grp_i[(r + 1) % GRP_N] == LO) &&
                    (grp_i[(r + GRP_N - 1) % GRP_N] == LO);
    if (r == 0) begin : g_first
      assign sel[r] = hit[r];
    end else begin : g_rest
      assign sel[r] = hit[r] && !(|hit[r-1:0]);
    end
  end

  // and-or mux over rotations, one chain per output channel
  for (genvar k = 0; k < DAT_N; k++) begin : g_ch
    assign acc[0][k] = '0;
    for (genvar r = 0; r < GRP_N; r++) begin : g_term
      assign acc[r+1][k] = acc[r][k] |
                           (sel[r] ? grp_i[(r + 2 + k) % GRP_N] : '0);
    end
    assign dat_o[k] = acc[GRP_N][k];
  end

  assign hit_o = |hit;

  always_comb begin
    p_sel_onehot_r7: assert ($onehot0(sel));
    p_sel_on_hit_r3: assert (hit_o == (|sel));
  end
endmodule

// File: rtl/adc_out_reg.sv
module adc_out_reg #(
  parameter int unsigned SMP_W = 8,
  parameter int unsigned DAT_N = 5
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        grp_vld_i,
  input  logic                        hit_i,
  input  logic [DAT_N-1:0][SMP_W-1:0] dat_i,
  output logic                        out_valid_o,
  output logic                        frame_error_o,
  output logic [DAT_N*SMP_W-1:0]      data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o   <= 1'b0;
      frame_error_o <= 1'b0;
      data_o        <= '0;
    end else begin
      out_valid_o   <= grp_vld_i && hit_i;
      frame_error_o <= grp_vld_i && !hit_i;
      if (grp_vld_i && hit_i) data_o <= dat_i;
    end
  end

  p_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_valid_o && frame_error_o));
  p_valid_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);
  p_err_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_error_o |=> !frame_error_o);
  p_data_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(data_o));
endmodule

// File: rtl/adc_frame_align.sv
module adc_frame_align
  import adc_align_pkg::*;
#(
  parameter int unsigned SMP_W = SMP_W_DEF,
  parameter int unsigned GRP_N = GRP_N_DEF,
  parameter int unsigned DAT_N = GRP_N - 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  input  logic [SMP_W-1:0]       sample_i,
  output logic                   out_valid_o,
  output logic [DAT_N*SMP_W-1:0] data_o,
  output logic                   frame_error_o
);
  logic                        grp_vld;
  logic [GRP_N-1:0][SMP_W-1:0] grp;
  logic                        hit;
  logic [DAT_N-1:0][SMP_W-1:0] dat;

  adc_grp_collect #(.SMP_W(SMP_W), .GRP_N(GRP_N)) u_collect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .sample_i   (sample_i),
    .grp_vld_o  (grp_vld),
    .grp_o      (grp)
  );

  adc_rot_match #(
    .SMP_W(SMP_W), .GRP_N(GRP_N),
    .HI(SMP_W'(MARK_HI)), .LO(SMP_W'(MARK_LO))
  ) u_match (
    .grp_i (grp),
    .hit_o (hit),
    .dat_o (dat)
  );

  adc_out_reg #(.SMP_W(SMP_W), .DAT_N(DAT_N)) u_out (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .grp_vld_i     (grp_vld),
    .hit_i         (hit),
    .dat_i         (dat),
    .out_valid_o   (out_valid_o),
    .frame_error_o (frame_error_o),
    .data_o        (data_o)
  );

  p_result_due_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_vld |=> (out_valid_o || frame_error_o));
  p_no_spurious_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o || frame_error_o) |-> $past(grp_vld));
endmodule

// File: tb/adc_frame_align_test.sv
module adc_frame_align_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // {samples in arrival order (pos 0 leftmost), ok, ch2..ch6 (ch2 leftmost)}
  localparam logic [104:0] TBL [NV] = '{
    {64'hFF00112233445500, 1'b1, 40'h1122334455}, // R3 rotation 0
    {64'hA4A500FF00A1A2A3, 1'b1, 40'hA1A2A3A4A5}, // R5 start at 3
    {64'h00B1B2B3B4B500FF, 1'b1, 40'hB1B2B3B4B5}, // R5 start at 7, wraps
    {64'hC1C2C3C4C500FF00, 1'b1, 40'hC1C2C3C4C5}, // R5 start at 6
    {64'h1020304050607080, 1'b0, 40'h0},          // R6 no marker
    {64'hFF00112233445566, 1'b0, 40'h0},          // R6 end marker missing
    {64'h00FF00D1D2D3D4D5, 1'b1, 40'hD1D2D3D4D5}, // R5 start at 1
    {64'hFF00FF00E1E2E300, 1'b1, 40'hFF00E1E2E3}, // R7 r=0 and r=2 match
    {64'h0000000000000000, 1'b0, 40'h0},          // R6 all low
    {64'h2233FF5500FF0011, 1'b1, 40'h112233FF55}  // R7 decoy FF in data
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  sample = '0;
  logic        out_valid, frame_error;
  logic [39:0] data;

  int n_chk = 0, n_fail = 0, cyc = 0, ev_n = 0;
  int ev_cyc [64];
  logic ev_ok [64];
  logic [39:0] ev_dat [64];
  int last_cyc;
  logic [39:0] prev_dat = '0;
  bit done = 0;

  adc_frame_align uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .sample_i(sample),
    .out_valid_o(out_valid), .data_o(data), .frame_error_o(frame_error)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if ((out_valid || frame_error) && ev_n < 64) begin
      ev_cyc[ev_n] = cyc;
      ev_ok[ev_n]  = out_valid;
      ev_dat[ev_n] = data;
      ev_n++;
    end
  end

  task automatic check(input bit c, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [39:0] to_port(input logic [39:0] d);
    logic [39:0] p;
    for (int k = 0; k < 5; k++) p[8*k +: 8] = d[39-8*k -: 8];
    return p;
  endfunction

  task automatic drive(input logic [7:0] s);
    @(negedge clk);
    in_valid = 1'b1;
    sample = s;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic send_group(input logic [63:0] g, input int gap);
    for (int i = 0; i < 8; i++) begin
      drive(g[63-8*i -: 8]);
      if (i == 7) last_cyc = cyc;
      else if (gap > 0) idle(gap);
    end
  endtask

  task automatic expect_ev(input int idx, input bit ok, input logic [39:0] d,
                           input int due, input string tag);
    check(ev_n > idx, {tag, " result present"}, ev_n, idx + 1);
    if (ev_n > idx) begin
      check(ev_ok[idx] == ok, {tag, " valid vs error"}, ev_ok[idx], ok);
      check(ev_cyc[idx] == due, {tag, " R8 latency"}, ev_cyc[idx], due);
      check(ev_dat[idx] == d, {tag, " data"}, ev_dat[idx], d);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check(!out_valid && !frame_error, "R1 outputs low in reset",
          {out_valid, frame_error}, 0);
    check(data == '0, "R1 data cleared", data, 0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    check(1'b0, "watchdog expired", done, 1);
    finish_run();
  end

  initial begin
    int base, due;
    logic [39:0] exp;
    do_reset();
    idle(2);
    check(ev_n == 0, "R1 no result after reset", ev_n, 0);

    // table walk, isolated groups
    for (int v = 0; v < NV; v++) begin
      base = ev_n;
      send_group(TBL[v][104:41], 0);
      due = last_cyc + 2;
      idle(5);
      exp = TBL[v][40] ? to_port(TBL[v][39:0]) : prev_dat;
      expect_ev(base, TBL[v][40], exp, due, $sformatf("R3/R4/R6 vector %0d", v));
      check(ev_n == base + 1, "R8 single pulse per group", ev_n, base + 1);
      check(data == exp, "R6 data_o after group", data, exp);
      prev_dat = exp;
    end

    // R1: partial group discarded by reset
    drive(8'hFF); drive(8'h00); drive(8'h11);
    idle(1);
    do_reset();
    base = ev_n;
    send_group(TBL[3][104:41], 0);
    due = last_cyc + 2;
    idle(5);
    expect_ev(base, 1'b1, to_port(TBL[3][39:0]), due, "R1 group after reset");
    check(ev_n == base + 1, "R1 one result after reset", ev_n, base + 1);
    prev_dat = to_port(TBL[3][39:0]);

    // R2: idle gaps inside a group
    base = ev_n;
    send_group(TBL[1][104:41], 2);
    due = last_cyc + 2;
    idle(5);
    expect_ev(base, 1'b1, to_port(TBL[1][39:0]), due, "R2 gapped group");
    check(ev_n == base + 1, "R2 one result", ev_n, base + 1);
    prev_dat = to_port(TBL[1][39:0]);

    // R9: back-to-back groups valid, error, valid
    begin
      int d0, d1, d2;
      base = ev_n;
      send_group(TBL[6][104:41], 0); d0 = last_cyc + 2;
      send_group(TBL[5][104:41], 0); d1 = last_cyc + 2;
      send_group(TBL[9][104:41], 0); d2 = last_cyc + 2;
      idle(5);
      expect_ev(base,     1'b1, to_port(TBL[6][39:0]), d0, "R9 first");
      expect_ev(base + 1, 1'b0, to_port(TBL[6][39:0]), d1, "R9 second");
      expect_ev(base + 2, 1'b1, to_port(TBL[9][39:0]), d2, "R9 third");
      check(ev_n == base + 3, "R9 three results", ev_n, base + 3);
    end

    done = 1;
    finish_run();
  end
endmodule